// File: doc/BRIEF.md
# Serial Scan Memory Test Controller

This block gives a tester with only a few slow pins full access to a bank of up to sixteen synchronous memories. A 112-bit command word is built in a single shift register. It is filled one bit per clock from a serial pin, or loaded all at once from a parallel 112-bit input. The word holds a 4-bit memory index and two complete port commands. Each port command carries an address, write data, an active-low chip select, an active-low write enable and a byte mask.

A memory-access strobe puts the decoded fields on the memory buses for exactly the cycles it is high. Only the chip select of the indexed memory may go low. Dual-port memories sit on one bus with two ports. Single-port memories sit on a second bus that has only one port. On the first clock edge after the strobe falls, the controller captures the read data into the data fields of the ports that issued a read. The result can then be shifted out serially, MSB first, or observed on the parallel output.

A mode input picks the path. In serial mode the scan-enable, serial data and serial access strobe are used. In parallel mode the parallel-load and parallel access strobes are used. The inputs of the path that is not selected are ignored.

Top module: `scan_mem_tester`

## Requirements
- R1: An active-high synchronous reset clears the whole command register to zero. The serial and parallel outputs then read zero, and every chip select on both buses is high.
- R2: In serial mode with scan enabled, each rising clock edge shifts the register left by one and takes the serial input into bit 0. The serial output always shows bit 111, so a word enters and leaves MSB first.
- R3: Word layout, MSB to LSB: memory index [111:108]; port 0 address [107:92], data [91:60], chip select [59], write enable [58], mask [57:54]; port 1 address [53:38], data [37:6], chip select [5], write enable [4], mask [3:0]. A port writes when chip select = 0 and write enable = 0. It reads when chip select = 0 and write enable = 1. It is idle when chip select = 1.
- R4: While the access strobe is high (serial mode: access strobe high and scan low), the chip-select bit of the indexed memory on a port equals that port's chip-select field. Every other chip select stays high, and all chip selects are high while the strobe is low.
- R5: On the first clock edge after the access strobe falls, each port that requested a read gets its data field replaced by the selected memory's read data for that port. The index, address, control and mask fields are unchanged.
- R6: The data field of a port that wrote or was idle is left as it was shifted in.
- R7: Mask bit i drives byte lane i of a write. A lane with mask bit 0 keeps its old memory contents.
- R8: Memories 0 to 4 sit on the dual-port bus. Memories 8 to 11 sit on the single-port bus, which carries port 0 only. A port 1 read aimed at a single-port memory returns zero in the port 1 data field.
- R9: An index that names no memory (5 to 7, 12 to 15) drives no chip select low, and the capture leaves the word unchanged.
- R10: In parallel mode the load strobe copies the 112-bit parallel input into the register. The parallel access strobe performs the access, and the parallel output always shows the register.
- R11: The inputs of the path that is not selected have no effect. In parallel mode the scan and serial inputs are ignored. In serial mode the parallel load strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the memories |
| rst | input | 1 | Synchronous reset, active high |
| serialMode | input | 1 | 1 selects the serial path, 0 the parallel path |
| serIn | input | 1 | Serial data in |
| serScan | input | 1 | Serial shift enable |
| serAccess | input | 1 | Serial-mode memory access strobe |
| parIn | input | 112 | Parallel command word |
| parLoad | input | 1 | Parallel-mode register load strobe |
| parAccess | input | 1 | Parallel-mode memory access strobe |
| serOut | output | 1 | Serial data out (register MSB) |
| parOut | output | 112 | Register contents |
| dAddr0 | output | 16 | Dual bus port 0 address |
| dDin0 | output | 32 | Dual bus port 0 write data |
| dWen0 | output | 1 | Dual bus port 0 write enable, active low |
| dMask0 | output | 4 | Dual bus port 0 byte mask |
| dAddr1 | output | 16 | Dual bus port 1 address |
| dDin1 | output | 32 | Dual bus port 1 write data |
| dWen1 | output | 1 | Dual bus port 1 write enable, active low |
| dMask1 | output | 4 | Dual bus port 1 byte mask |
| dCs0n | output | 16 | Dual bus port 0 chip selects, one per memory, active low |
| dCs1n | output | 16 | Dual bus port 1 chip selects, active low |
| sAddr0 | output | 16 | Single bus address |
| sDin0 | output | 32 | Single bus write data |
| sWen0 | output | 1 | Single bus write enable, active low |
| sMask0 | output | 4 | Single bus byte mask |
| sCs0n | output | 16 | Single bus chip selects, active low |
| rdData0 | input | 512 | Port 0 read data, 32 bits per memory, memory m at [32m+31:32m] |
| rdData1 | input | 512 | Port 1 read data, same packing |

## Verification
The bench sends a full write followed by a dual-port read of the same word on both ports. This shows that each port's data field is replaced by its own read data and not by the other port's. A masked write over known contents separates byte-lane gating from whole-word writes, and the narrow memory 0 shows that its upper read bits come back as zero. A single-port memory read with a port 1 request, and an index that names no memory, separate the two buses and the unmapped case. In both, the chip-select vectors are sampled during the strobe. The parallel path is loaded, disturbed through the serial inputs, and then used for a read, which shows that mode selection isolates the two paths.

// File: rtl/scan_mem_pkg.sv
package scan_mem_pkg;
  // Strobes from control to datapath; at most one register update per cycle
  typedef struct packed {
    logic shiftEn;   // serial shift of the command word
    logic wordLoad;  // parallel load of the command word
    logic memEn;     // fields presented to the memories
    logic capture;   // first edge after memEn falls
  } ctlStrobe_t;
endpackage

// File: rtl/scan_mem_ctl.sv
module scan_mem_ctl
  import scan_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       serialMode,
  input  logic       serScan,
  input  logic       serAccess,
  input  logic       parLoad,
  input  logic       parAccess,
  output ctlStrobe_t strobes
);
  logic memEnQ;
  logic memEnNow;

  always_comb begin
    memEnNow = serialMode ? (serAccess & ~serScan) : parAccess;
    strobes.memEn    = memEnNow;
    strobes.capture  = memEnQ & ~memEnNow;
    strobes.shiftEn  = serialMode & serScan;
    strobes.wordLoad = ~serialMode & parLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) memEnQ <= 1'b0;
    else     memEnQ <= memEnNow;
  end

  // R5: a capture lasts a single cycle
  a_r5_capture_single: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> !strobes.capture);

  // R11: a serial scan never opens a memory access in serial mode
  a_r11_scan_blocks_access: assert property (@(posedge clk) disable iff (rst)
    (serialMode && serScan) |-> !strobes.memEn);
endmodule

// File: rtl/scan_mem_dp.sv
module scan_mem_dp
  import scan_mem_pkg::*;
#(
  parameter int NMEM   = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter logic [NMEM-1:0] DUAL_MAP   = 16'h001F,
  parameter logic [NMEM-1:0] SINGLE_MAP = 16'h0F00,
  localparam int SEL_W  = $clog2(NMEM),
  localparam int PORT_W = ADDR_W + DATA_W + 2 + MASK_W,
  localparam int PKT_W  = SEL_W + 2 * PORT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         strobes,
  input  logic               serIn,
  input  logic [PKT_W-1:0]   parIn,
  input  logic [NMEM*DATA_W-1:0] rdData0,
  input  logic [NMEM*DATA_W-1:0] rdData1,
  output logic [PKT_W-1:0]   word,
  output logic [ADDR_W-1:0]  portAddr [2],
  output logic [DATA_W-1:0]  portData [2],
  output logic               portWen  [2],
  output logic [MASK_W-1:0]  portMask [2],
  output logic [NMEM-1:0]    dCs0n,
  output logic [NMEM-1:0]    dCs1n,
  output logic [NMEM-1:0]    sCs0n
);
  localparam int P0_DATA_LO = PORT_W + MASK_W + 2;
  localparam int P1_DATA_LO = MASK_W + 2;

  logic [SEL_W-1:0] memSel;
  logic [NMEM-1:0]  selOh;
  logic             portCs [2];
  logic             onDual, onSingle;
  logic [DATA_W-1:0] rdVal0, rdVal1;
  logic [1:0]       rdPend;

  assign memSel = word[PKT_W-1 -: SEL_W];

  // Field extraction, port 0 above port 1
  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int BASE = (1 - p) * PORT_W;
    assign portMask[p] = word[BASE +: MASK_W];
    assign portWen[p]  = word[BASE + MASK_W];
    assign portCs[p]   = word[BASE + MASK_W + 1];
    assign portData[p] = word[BASE + MASK_W + 2 +: DATA_W];
    assign portAddr[p] = word[BASE + MASK_W + 2 + DATA_W +: ADDR_W];
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_sel
    assign selOh[m] = (memSel == SEL_W'(m));
  end

  assign onDual   = |(selOh & DUAL_MAP);
  assign onSingle = |(selOh & SINGLE_MAP);

  // Chip-select decode, active low, gated by the access strobe
  always_comb begin
    dCs0n = ~(selOh & DUAL_MAP   & {NMEM{strobes.memEn & ~portCs[0]}});
    dCs1n = ~(selOh & DUAL_MAP   & {NMEM{strobes.memEn & ~portCs[1]}});
    sCs0n = ~(selOh & SINGLE_MAP & {NMEM{strobes.memEn & ~portCs[0]}});
  end

  // Read-data selection
  always_comb begin
    rdVal0 = '0;
    rdVal1 = '0;
    for (int m = 0; m < NMEM; m++) begin
      if (selOh[m]) begin
        rdVal0 = rdData0[m*DATA_W +: DATA_W];
        rdVal1 = SINGLE_MAP[m] ? '0 : rdData1[m*DATA_W +: DATA_W];
      end
    end
  end

  // Remember which ports read during the access
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPend <= '0;
    end else if (strobes.memEn) begin
      rdPend[0] <= (onDual | onSingle) & ~portCs[0] & portWen[0];
      rdPend[1] <= (onDual | onSingle) & ~portCs[1] & portWen[1];
    end
  end

  // Command register: capture > parallel load > shift
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (strobes.capture) begin
      if (rdPend[0]) word[P0_DATA_LO +: DATA_W] <= rdVal0;
      if (rdPend[1]) word[P1_DATA_LO +: DATA_W] <= rdVal1;
    end else if (strobes.wordLoad) begin
      word <= parIn;
    end else if (strobes.shiftEn) begin
      word <= {word[PKT_W-2:0], serIn};
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (word == '0));

  a_r2_shift_lsb: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftEn && !strobes.capture && !strobes.wordLoad)
      |=> (word[0] == $past(serIn)) && (word[PKT_W-1:1] == $past(word[PKT_W-2:0])));

  a_r4_one_cs_per_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dCs0n) && $onehot0(~dCs1n) && $onehot0(~sCs0n));

  a_r4_idle_all_high: assert property (@(posedge clk) disable iff (rst)
    !strobes.memEn |-> (&dCs0n && &dCs1n && &sCs0n));

  a_r5_fields_kept: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> $stable(word[PKT_W-1 -: SEL_W + ADDR_W])
                     && $stable(word[PORT_W-1 -: ADDR_W]));

  a_r8_buses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((~&dCs0n || ~&dCs1n) && ~&sCs0n));

  a_r8_single_no_port1: assert property (@(posedge clk) disable iff (rst)
    (~&sCs0n) |-> &dCs1n);
endmodule

// File: rtl/scan_mem_tester.sv
module scan_mem_tester
  import scan_mem_pkg::*;
#(
  parameter int NMEM   = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4,
  parameter logic [NMEM-1:0] DUAL_MAP   = 16'h001F,
  parameter logic [NMEM-1:0] SINGLE_MAP = 16'h0F00,
  localparam int SEL_W  = $clog2(NMEM),
  localparam int PKT_W  = SEL_W + 2 * (ADDR_W + DATA_W + 2 + MASK_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   serialMode,
  input  logic                   serIn,
  input  logic                   serScan,
  input  logic                   serAccess,
  input  logic [PKT_W-1:0]       parIn,
  input  logic                   parLoad,
  input  logic                   parAccess,
  output logic                   serOut,
  output logic [PKT_W-1:0]       parOut,
  output logic [ADDR_W-1:0]      dAddr0,
  output logic [DATA_W-1:0]      dDin0,
  output logic                   dWen0,
  output logic [MASK_W-1:0]      dMask0,
  output logic [ADDR_W-1:0]      dAddr1,
  output logic [DATA_W-1:0]      dDin1,
  output logic                   dWen1,
  output logic [MASK_W-1:0]      dMask1,
  output logic [NMEM-1:0]        dCs0n,
  output logic [NMEM-1:0]        dCs1n,
  output logic [ADDR_W-1:0]      sAddr0,
  output logic [DATA_W-1:0]      sDin0,
  output logic                   sWen0,
  output logic [MASK_W-1:0]      sMask0,
  output logic [NMEM-1:0]        sCs0n,
  input  logic [NMEM*DATA_W-1:0] rdData0,
  input  logic [NMEM*DATA_W-1:0] rdData1
);
  ctlStrobe_t        strobes;
  logic [PKT_W-1:0]  word;
  logic [ADDR_W-1:0] portAddr [2];
  logic [DATA_W-1:0] portData [2];
  logic              portWen  [2];
  logic [MASK_W-1:0] portMask [2];

  scan_mem_ctl u_ctl (
    .clk(clk), .rst(rst), .serialMode(serialMode), .serScan(serScan),
    .serAccess(serAccess), .parLoad(parLoad), .parAccess(parAccess),
    .strobes(strobes)
  );

  scan_mem_dp #(
    .NMEM(NMEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W),
    .DUAL_MAP(DUAL_MAP), .SINGLE_MAP(SINGLE_MAP)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .serIn(serIn), .parIn(parIn),
    .rdData0(rdData0), .rdData1(rdData1), .word(word),
    .portAddr(portAddr), .portData(portData), .portWen(portWen),
    .portMask(portMask), .dCs0n(dCs0n), .dCs1n(dCs1n), .sCs0n(sCs0n)
  );

  assign serOut = word[PKT_W-1];
  assign parOut = word;
  assign dAddr0 = portAddr[0];
  assign dDin0  = portData[0];
  assign dWen0  = portWen[0];
  assign dMask0 = portMask[0];
  assign dAddr1 = portAddr[1];
  assign dDin1  = portData[1];
  assign dWen1  = portWen[1];
  assign dMask1 = portMask[1];
  assign sAddr0 = portAddr[0];
  assign sDin0  = portData[0];
  assign sWen0  = portWen[0];
  assign sMask0 = portMask[0];
endmodule

// File: tb/scan_mem_tester_tb.sv
`timescale 1ns/1ps
module scan_mem_tester_tb;
  logic clk = 1'b0;
  logic rst;
  logic serialMode, serIn, serScan, serAccess, parLoad, parAccess;
  logic [111:0] parIn;
  logic serOut;
  logic [111:0] parOut;
  logic [15:0] dAddr0, dAddr1, sAddr0;
  logic [31:0] dDin0, dDin1, sDin0;
  logic dWen0, dWen1, sWen0;
  logic [3:0] dMask0, dMask1, sMask0;
  logic [15:0] dCs0n, dCs1n, sCs0n;
  logic [511:0] rdData0, rdData1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scan_mem_tester u_dut (
    .clk(clk), .rst(rst), .serialMode(serialMode), .serIn(serIn),
    .serScan(serScan), .serAccess(serAccess), .parIn(parIn),
    .parLoad(parLoad), .parAccess(parAccess), .serOut(serOut),
    .parOut(parOut), .dAddr0(dAddr0), .dDin0(dDin0), .dWen0(dWen0),
    .dMask0(dMask0), .dAddr1(dAddr1), .dDin1(dDin1), .dWen1(dWen1),
    .dMask1(dMask1), .dCs0n(dCs0n), .dCs1n(dCs1n), .sAddr0(sAddr0),
    .sDin0(sDin0), .sWen0(sWen0), .sMask0(sMask0), .sCs0n(sCs0n),
    .rdData0(rdData0), .rdData1(rdData1)
  );

  // Behavioural memories: 0..4 dual-port (0 is 8 bits wide), 8..11 single-port
  logic [31:0] memArr [16][64];
  logic [31:0] rd0q [16];
  logic [31:0] rd1q [16];
  logic [31:0] shadow [16][64];

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldV,
      input logic [31:0] newV, input logic [3:0] mask);
    logic [31:0] r = oldV;
    for (int b = 0; b < 4; b++) if (mask[b]) r[b*8 +: 8] = newV[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] narrowFix(input int m, input logic [31:0] v);
    return (m == 0) ? {24'h0, v[7:0]} : v;
  endfunction

  initial begin
    for (int m = 0; m < 16; m++) begin
      rd0q[m] = '0; rd1q[m] = '0;
      for (int a = 0; a < 64; a++) begin memArr[m][a] = '0; shadow[m][a] = '0; end
    end
  end

  always @(posedge clk) begin
    for (int m = 0; m < 16; m++) begin
      if (m <= 4) begin
        if (!dCs0n[m]) begin
          if (!dWen0) memArr[m][dAddr0[5:0]] <= mergeBytes(memArr[m][dAddr0[5:0]], dDin0, dMask0);
          else        rd0q[m] <= narrowFix(m, memArr[m][dAddr0[5:0]]);
        end
        if (!dCs1n[m]) rd1q[m] <= narrowFix(m, memArr[m][dAddr1[5:0]]);
      end else if (m >= 8 && m <= 11) begin
        if (!sCs0n[m]) begin
          if (!sWen0) memArr[m][sAddr0[5:0]] <= mergeBytes(memArr[m][sAddr0[5:0]], sDin0, sMask0);
          else        rd0q[m] <= memArr[m][sAddr0[5:0]];
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < 16; m++) begin
      rdData0[m*32 +: 32] = rd0q[m];
      rdData1[m*32 +: 32] = rd1q[m];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [111:0] act,
                       input logic [111:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [111:0] expQ [$];
  logic [111:0] gotWord;
  string        gotTag;
  event         outEv;

  always @(outEv) begin
    logic [111:0] e;
    if (expQ.size() == 0) begin
      check(1'b0, "R5 scoreboard empty", gotWord, '0);
    end else begin
      e = expQ.pop_front();
      check(gotWord === e, gotTag, gotWord, e);
    end
  end

  function automatic logic [111:0] mkPkt(input logic [3:0] sel,
      input logic [15:0] a0, input logic [31:0] d0, input logic c0, input logic w0, input logic [3:0] k0,
      input logic [15:0] a1, input logic [31:0] d1, input logic c1, input logic w1, input logic [3:0] k1);
    return {sel, a0, d0, c0, w0, k0, a1, d1, c1, w1, k1};
  endfunction

  // Driver: predict, push, then run the serial sequence
  task automatic runSerial(input logic [111:0] pkt, input string tag);
    logic [111:0] e = pkt;
    int sel = int'(pkt[111:108]);
    bit isDual = (sel <= 4);
    bit isSingle = (sel >= 8 && sel <= 11);
    bit rd0 = !pkt[59] && pkt[58];
    bit wr0 = !pkt[59] && !pkt[58];
    bit rd1 = !pkt[5] && pkt[4];
    logic [15:0] expD0, expD1, expS0;
    logic [111:0] outW;
    // R3, R5, R8, R9 prediction
    if ((isDual || isSingle) && rd0) e[91:60] = narrowFix(sel, shadow[sel][pkt[97:92]]);
    if (isDual && rd1)   e[37:6] = narrowFix(sel, shadow[sel][pkt[43:38]]);
    if (isSingle && rd1) e[37:6] = '0;
    if ((isDual || isSingle) && wr0)
      shadow[sel][pkt[97:92]] = mergeBytes(shadow[sel][pkt[97:92]], pkt[91:60], pkt[57:54]);
    expD0 = (isDual && !pkt[59]) ? ~(16'h1 << sel) : 16'hFFFF;
    expD1 = (isDual && !pkt[5])  ? ~(16'h1 << sel) : 16'hFFFF;
    expS0 = (isSingle && !pkt[59]) ? ~(16'h1 << sel) : 16'hFFFF;
    expQ.push_back(e);
    for (int j = 0; j < 112; j++) begin
      serScan = 1'b1; serIn = pkt[111 - j];
      @(negedge clk);
    end
    // R2: shifted word visible in full
    check(parOut === pkt, {"R2 shift-in ", tag}, parOut, pkt);
    serScan = 1'b0; serAccess = 1'b1;
    #1;
    // R4: chip selects during the strobe
    check(dCs0n === expD0 && dCs1n === expD1 && sCs0n === expS0, {"R4 cs ", tag},
          {64'h0, dCs0n, dCs1n, sCs0n}, {64'h0, expD0, expD1, expS0});
    @(negedge clk);
    serAccess = 1'b0;
    #1;
    check(&dCs0n && &dCs1n && &sCs0n, {"R4 cs idle ", tag}, {64'h0, dCs0n, dCs1n, sCs0n}, {112{1'b1}} >> 64);
    @(negedge clk);
    for (int j = 0; j < 112; j++) begin
      outW[111 - j] = serOut;
      serScan = 1'b1; serIn = 1'b0;
      @(negedge clk);
    end
    serScan = 1'b0;
    gotWord = outW; gotTag = {"R5 R6 readout ", tag};
    ->outEv;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [111:0] pkt;
    rst = 1'b1; serialMode = 1'b1; serIn = 1'b0; serScan = 1'b0; serAccess = 1'b0;
    parIn = '0; parLoad = 1'b0; parAccess = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check(parOut === '0 && serOut === 1'b0, "R1 reset word", parOut, '0);
    check(&dCs0n && &dCs1n && &sCs0n, "R1 reset cs", {64'h0, dCs0n, dCs1n, sCs0n}, {112{1'b1}} >> 64);
    @(negedge clk);

    // R3 write to dual memory 1, port 1 idle
    runSerial(mkPkt(4'd1, 16'd3, 32'hDEADBEEF, 0, 0, 4'hF, 16'd0, 32'h0, 1, 1, 4'h0), "mem1 write");
    // R5 dual read on both ports
    runSerial(mkPkt(4'd1, 16'd3, 32'h0, 0, 1, 4'h0, 16'd3, 32'h0, 0, 1, 4'h0), "mem1 dual read");
    // R7 masked write
    runSerial(mkPkt(4'd2, 16'd5, 32'h11223344, 0, 0, 4'hF, 16'd0, 32'h0, 1, 1, 4'h0), "mem2 full write");
    runSerial(mkPkt(4'd2, 16'd5, 32'hAABBCCDD, 0, 0, 4'h5, 16'd0, 32'h0, 1, 1, 4'h0), "R7 mem2 masked write");
    runSerial(mkPkt(4'd2, 16'd5, 32'h0, 0, 1, 4'h0, 16'd9, 32'h55AA55AA, 1, 1, 4'h0), "R7 mem2 read");
    // Narrow memory 0
    runSerial(mkPkt(4'd0, 16'd7, 32'h12345678, 0, 0, 4'hF, 16'd0, 32'h0, 1, 1, 4'h0), "mem0 write");
    runSerial(mkPkt(4'd0, 16'd7, 32'hFFFFFFFF, 0, 1, 4'h0, 16'd7, 32'h0, 0, 1, 4'h0), "mem0 narrow read");
    // R6 port 0 writes while port 1 reads other word of memory 4
    runSerial(mkPkt(4'd4, 16'd1, 32'h0BADCAFE, 0, 0, 4'hF, 16'd0, 32'h0, 1, 1, 4'h0), "mem4 setup");
    runSerial(mkPkt(4'd4, 16'd2, 32'h13572468, 0, 0, 4'hF, 16'd1, 32'h99999999, 0, 1, 4'h0), "R6 mem4 write+read");
    // R8 single-port memory 9
    runSerial(mkPkt(4'd9, 16'd7, 32'hCAFEF00D, 0, 0, 4'hF, 16'd0, 32'h0, 1, 1, 4'h0), "R8 mem9 write");
    runSerial(mkPkt(4'd9, 16'd7, 32'h0, 0, 1, 4'h0, 16'd7, 32'h77777777, 0, 1, 4'h0), "R8 mem9 read");
    // R9 unmapped index
    runSerial(mkPkt(4'd6, 16'd3, 32'h31415926, 0, 1, 4'h0, 16'd3, 32'h27182818, 0, 1, 4'h0), "R9 unmapped");

    // R10 parallel path
    serialMode = 1'b0;
    pkt = mkPkt(4'd1, 16'd3, 32'h0, 0, 1, 4'h0, 16'd3, 32'hABCDEF01, 1, 1, 4'h0);
    parIn = pkt; parLoad = 1'b1;
    @(negedge clk);
    parLoad = 1'b0;
    check(parOut === pkt, "R10 parallel load", parOut, pkt);
    // R11 serial inputs ignored in parallel mode
    serScan = 1'b1; serIn = 1'b1; serAccess = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(parOut === pkt && &dCs0n, "R11 serial ignored", parOut, pkt);
    serScan = 1'b0; serIn = 1'b0; serAccess = 1'b0;
    @(negedge clk);
    parAccess = 1'b1;
    @(negedge clk);
    parAccess = 1'b0;
    @(negedge clk);
    pkt[91:60] = 32'hDEADBEEF;
    check(parOut === pkt, "R10 parallel read", parOut, pkt);
    // R11 parallel load ignored in serial mode
    serialMode = 1'b1;
    parIn = ~pkt; parLoad = 1'b1;
    @(negedge clk);
    parLoad = 1'b0;
    check(parOut === pkt, "R11 parallel load ignored", parOut, pkt);

    // R1 reset mid-word
    serScan = 1'b1; serIn = 1'b1;
    repeat (5) @(negedge clk);
    serScan = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(parOut === '0, "R1 reset mid-word", parOut, '0);

    @(negedge clk);
    check(expQ.size() == 0, "R5 scoreboard drained", 112'(expQ.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule